// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox Unit

The unit holds one 32-bit doorbell mailbox per core and is used to raise inter-processor interrupts. Every core has its own write port and its own read port into a small address window. A core rings another core by writing a bit mask to that core's set address. The unit ORs the mask into the target mailbox. Each mailbox bit is an independent doorbell.

The target core reads its mailbox through its clear address. It acknowledges doorbells by writing ones to that same address, which clears only those bits. Whenever a mailbox is non-zero, the unit drives a summary line toward the interrupt aggregator. It also presents the index of the lowest pending bit, which the receiver handles next.

The set address of core N is `SET_BASE + 16*N` and the clear address is `CLR_BASE + 16*N`. All cores may write in the same cycle. When a set write and a clear write reach the same bit in one cycle, the set takes effect, so a doorbell is never lost.

Top module: `mbx_doorbell_unit`

## Requirements
- R1: A write of mask M to byte address `SET_BASE + 16*N` (defaults `SET_BASE`=0x80, four cores) makes mailbox N equal to its old value OR M from the following cycle; its other bits are unchanged.
- R2: A write of mask M to `CLR_BASE + 16*N` (default `CLR_BASE`=0xC0) clears exactly the bits of M in mailbox N from the following cycle.
- R3: On read port P, an address equal to `CLR_BASE + 16*N` returns the current 32-bit contents of mailbox N combinationally; any other read address returns zero.
- R4: Writes from different ports in the same cycle all take effect; several set masks aimed at one mailbox OR together, and set bits accumulate over cycles until cleared.
- R5: When a set and a clear reach the same bit of a mailbox in the same cycle, the bit ends up set.
- R6: `irq_o[N]` is high exactly when mailbox N is non-zero.
- R7: `next_id_o` field N (5 bits, field N at bits [5N+4:5N]) gives the index of the lowest set bit of mailbox N, and 0 when the mailbox is empty.
- R8: While `rst_ni` is low, all mailboxes are zero.
- R9: Writes to any address other than the set and clear addresses of existing cores change no mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | NUM_CORES | Write strobe, one per core port |
| wr_addr_i | input | NUM_CORES*AW | Write byte address, port P at bits [AW*P +: AW] |
| wr_data_i | input | NUM_CORES*32 | Write mask, port P at bits [32*P +: 32] |
| rd_addr_i | input | NUM_CORES*AW | Read byte address per port |
| rd_data_o | output | NUM_CORES*32 | Read data per port |
| irq_o | output | NUM_CORES | Per-mailbox non-empty summary |
| next_id_o | output | NUM_CORES*5 | Lowest pending doorbell index per mailbox |

## Verification
Two events can meet in one cycle: a sender's set write and the receiver's acknowledge write to the same mailbox, from two different ports. The bench provokes this with overlapping masks, and also with writes arriving at random on all ports at once. After each cycle it compares every mailbox, read through its clear address, with a model that applies clear first and then set. Any bit present in both masks must read as one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DW     = 32;
  localparam int unsigned MBX_IW     = $clog2(MBX_DW);
  localparam int unsigned MBX_STRIDE = 16;
  typedef logic [MBX_DW-1:0] mbx_word_t;
  typedef logic [MBX_IW-1:0] mbx_idx_t;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned AW        = 8,
  parameter int unsigned BASE      = 'h80
) (
  input  logic                 en_i,
  input  logic [AW-1:0]        addr_i,
  output logic [NUM_CORES-1:0] hit_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_hit
    localparam logic [AW-1:0] SLOT_ADDR = AW'(BASE + MBX_STRIDE * c);
    assign hit_o[c] = en_i && (addr_i == SLOT_ADDR);
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_CORES-1:0]        set_hit_i,
  input  logic [NUM_CORES-1:0]        clr_hit_i,
  input  logic [NUM_CORES*MBX_DW-1:0] wr_data_i,
  output mbx_word_t                   q_o
);
  mbx_word_t set_m, clr_m, q;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int p = 0; p < NUM_CORES; p++) begin
      if (set_hit_i[p]) set_m |= wr_data_i[MBX_DW*p +: MBX_DW];
      if (clr_hit_i[p]) clr_m |= wr_data_i[MBX_DW*p +: MBX_DW];
    end
  end

  // clear applied first so a colliding set survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_m) | set_m;
  end

  assign q_o = q;

  // R1 R5
  set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_m) |=> ((q & $past(set_m)) == $past(set_m)));

  // R2
  clr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_m) |=> ((q & $past(clr_m & ~set_m)) == '0));

  // R9
  untouched_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q & ~$past(set_m | clr_m)) == ($past(q) & ~$past(set_m | clr_m))));
endmodule

// File: rtl/mbx_lsb.sv
module mbx_lsb
  import mbx_pkg::*;
(
  input  mbx_word_t vec_i,
  output mbx_idx_t  idx_o,
  output logic      vld_o
);
  always_comb begin
    idx_o = '0;
    for (int i = MBX_DW - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = MBX_IW'(i);
    end
    vld_o = |vec_i;
  end
endmodule

// File: rtl/mbx_doorbell_unit.sv
module mbx_doorbell_unit
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned AW        = 8,
  parameter int unsigned SET_BASE  = 'h80,
  parameter int unsigned CLR_BASE  = 'hC0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_CORES-1:0]        wr_en_i,
  input  logic [NUM_CORES*AW-1:0]     wr_addr_i,
  input  logic [NUM_CORES*MBX_DW-1:0] wr_data_i,
  input  logic [NUM_CORES*AW-1:0]     rd_addr_i,
  output logic [NUM_CORES*MBX_DW-1:0] rd_data_o,
  output logic [NUM_CORES-1:0]        irq_o,
  output logic [NUM_CORES*MBX_IW-1:0] next_id_o
);
  // hits indexed [port][core]
  logic [NUM_CORES-1:0][NUM_CORES-1:0] set_hit, clr_hit, rd_hit;
  logic [NUM_CORES-1:0][NUM_CORES-1:0] set_col, clr_col;
  mbx_word_t q [NUM_CORES];
  mbx_idx_t  lsb_idx [NUM_CORES];
  logic      lsb_vld [NUM_CORES];

  for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
    mbx_addr_dec #(.NUM_CORES(NUM_CORES), .AW(AW), .BASE(SET_BASE)) u_set_dec (
      .en_i(wr_en_i[p]), .addr_i(wr_addr_i[AW*p +: AW]), .hit_o(set_hit[p]));
    mbx_addr_dec #(.NUM_CORES(NUM_CORES), .AW(AW), .BASE(CLR_BASE)) u_clr_dec (
      .en_i(wr_en_i[p]), .addr_i(wr_addr_i[AW*p +: AW]), .hit_o(clr_hit[p]));
    mbx_addr_dec #(.NUM_CORES(NUM_CORES), .AW(AW), .BASE(CLR_BASE)) u_rd_dec (
      .en_i(1'b1), .addr_i(rd_addr_i[AW*p +: AW]), .hit_o(rd_hit[p]));

    always_comb begin
      rd_data_o[MBX_DW*p +: MBX_DW] = '0;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (rd_hit[p][c]) rd_data_o[MBX_DW*p +: MBX_DW] = q[c];
      end
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar p = 0; p < NUM_CORES; p++) begin : g_col
      assign set_col[c][p] = set_hit[p][c];
      assign clr_col[c][p] = clr_hit[p][c];
    end

    mbx_slot #(.NUM_CORES(NUM_CORES)) u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_hit_i(set_col[c]), .clr_hit_i(clr_col[c]),
      .wr_data_i(wr_data_i), .q_o(q[c]));

    mbx_lsb u_lsb (.vec_i(q[c]), .idx_o(lsb_idx[c]), .vld_o(lsb_vld[c]));

    assign irq_o[c] = lsb_vld[c];
    assign next_id_o[MBX_IW*c +: MBX_IW] = lsb_idx[c];

    // R7
    lowest_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (q[c][lsb_idx[c]] &&
                   ((q[c] & ((MBX_DW'(1) << lsb_idx[c]) - MBX_DW'(1))) == '0)));

    // R6
    empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q[c] == '0) |-> (!irq_o[c] && lsb_idx[c] == '0));
  end
endmodule

// File: tb/mbx_doorbell_unit_bench.sv
`timescale 1ns/1ps
module mbx_doorbell_unit_bench;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int IW = 5;
  localparam int SET_B = 'h80;
  localparam int CLR_B = 'hC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            we [NC];
  logic [AW-1:0]   wa [NC];
  logic [DW-1:0]   wd [NC];
  logic [AW-1:0]   ra [NC];
  logic [DW-1:0]   mdl [NC];

  logic [NC-1:0]    wr_en;
  logic [NC*AW-1:0] wr_addr, rd_addr;
  logic [NC*DW-1:0] wr_data, rd_data;
  logic [NC-1:0]    irq;
  logic [NC*IW-1:0] next_id;

  always_comb begin
    for (int p = 0; p < NC; p++) begin
      wr_en[p]            = we[p];
      wr_addr[AW*p +: AW] = wa[p];
      wr_data[DW*p +: DW] = wd[p];
      rd_addr[AW*p +: AW] = ra[p];
    end
  end

  mbx_doorbell_unit #(.NUM_CORES(NC), .AW(AW), .SET_BASE(SET_B), .CLR_BASE(CLR_B)) u_mbx_doorbell_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .next_id_o(next_id));

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lowest(logic [31:0] v);
    for (int i = 0; i < DW; i++) if (v[i]) return 32'(i);
    return 32'd0;
  endfunction

  function automatic logic [AW-1:0] set_a(int c);
    return AW'(SET_B + 16 * c);
  endfunction
  function automatic logic [AW-1:0] clr_a(int c);
    return AW'(CLR_B + 16 * c);
  endfunction

  task automatic put(int p, logic [AW-1:0] a, logic [31:0] d);
    we[p] = 1'b1; wa[p] = a; wd[p] = d;
  endtask

  task automatic check_all();
    for (int c = 0; c < NC; c++) ra[c] = clr_a(c);
    #1;
    for (int c = 0; c < NC; c++) begin
      chk("R3 read mailbox", rd_data[DW*c +: DW], mdl[c]);
      chk("R6 irq", 32'(irq[c]), 32'(|mdl[c]));
      chk("R7 next id", 32'(next_id[IW*c +: IW]), lowest(mdl[c]));
    end
    ra[0] = set_a(1);
    #1;
    chk("R3 non-clear read zero", rd_data[DW-1:0], 32'd0);
    ra[0] = clr_a(0);
  endtask

  // called at a negedge with writes already placed
  task automatic step();
    logic [31:0] sm [NC];
    logic [31:0] cm [NC];
    for (int c = 0; c < NC; c++) begin sm[c] = '0; cm[c] = '0; end
    for (int p = 0; p < NC; p++) begin
      if (we[p]) begin
        for (int c = 0; c < NC; c++) begin
          if (wa[p] == set_a(c)) sm[c] |= wd[p];
          if (wa[p] == clr_a(c)) cm[c] |= wd[p];
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) mdl[c] = (mdl[c] & ~cm[c]) | sm[c];
    for (int p = 0; p < NC; p++) we[p] = 1'b0;
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < NC; p++) begin
      we[p] = 1'b0; wa[p] = '0; wd[p] = '0; ra[p] = clr_a(p); mdl[p] = '0;
    end
    repeat (3) @(negedge clk);
    // R8 reset state
    check_all();
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 accumulate one bit at a time from rotating senders; R2 R7 clear lowest upward
    for (int t = 0; t < NC; t++) begin
      for (int b = 0; b < DW; b++) begin
        put((t + b) % NC, set_a(t), 32'(1) << b);
        step();
      end
      for (int b = 0; b < DW; b++) begin
        put(t, clr_a(t), 32'(1) << b);
        step();
      end
    end

    // R4 all ports hit one mailbox in one cycle, plus distinct targets
    put(0, set_a(2), 32'h0000_0011);
    put(1, set_a(2), 32'h0000_0F00);
    put(2, set_a(2), 32'h8000_0000);
    put(3, set_a(2), 32'h0010_0000);
    step();
    put(0, set_a(0), 32'hA5A5_0000);
    put(1, set_a(1), 32'h0000_5A5A);
    put(2, set_a(3), 32'h0F0F_F0F0);
    put(3, clr_a(2), 32'h0000_0001);
    step();

    // R5 set and clear collide on the same bits
    put(0, set_a(1), 32'h0000_FFFF);
    put(1, clr_a(1), 32'h00FF_00FF);
    step();
    chk("R5 set wins", rd_data[DW*1 +: DW], (32'h0000_5A5A & ~32'h00FF_00FF) | 32'h0000_FFFF);

    // R9 stray addresses
    put(0, AW'(SET_B + 4), 32'hFFFF_FFFF);
    put(1, AW'(CLR_B + 8), 32'hFFFF_FFFF);
    put(2, AW'(8'h7F), 32'hFFFF_FFFF);
    put(3, AW'(8'hF8), 32'hFFFF_FFFF);
    step();
    put(0, AW'(8'h00), 32'hFFFF_FFFF);
    put(2, AW'(CLR_B + 1), 32'hFFFF_FFFF);
    step();

    // R4 R5 random traffic on all ports
    for (int k = 0; k < 300; k++) begin
      for (int p = 0; p < NC; p++) begin
        int sel;
        sel = int'($urandom_range(0, 9));
        if (sel < 4)      put(p, set_a(int'($urandom_range(0, NC - 1))), $urandom & $urandom);
        else if (sel < 8) put(p, clr_a(int'($urandom_range(0, NC - 1))), $urandom | $urandom);
        else if (sel < 9) put(p, AW'($urandom), $urandom);
      end
      step();
    end

    // R8 mid-run reset
    for (int p = 0; p < NC; p++) put(p, set_a(p), 32'hDEAD_BEEF);
    step();
    rst_n = 1'b0;
    #1;
    for (int c = 0; c < NC; c++) mdl[c] = '0;
    check_all();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule